// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block turns internal access requests into read and write cycles on an external memory bus that is split into eight address areas. Each area has its own active-low chip select. The area is taken from the top three address bits. A cycle has two states (T1, T2), or three states (T1, T2, T3) when the request asks for a long access.

Some devices are slow to release the data bus after a read. To protect against this, the sequencer can hold back the first state of the next cycle by one or two idle states when one of three transitions occurs:

- a read that follows a read to a different area;
- a write that follows a read;
- a read that follows a write.

Each transition has its own enable bit in a small configuration register. One further bit in that register selects an idle length of one or two states. During an idle state the bus is quiet: no chip select is active, both strobes are high and the data output is released.

Requests use a valid/ready handshake. Ready is high while the bus is free and in the last state of every cycle, so a waiting request can follow with no dead clock.

The states are:

- `ST_FREE`: no cycle.
- `ST_GAP_A`: the first of two idle states.
- `ST_GAP_B`: the last idle state.
- `ST_T1`, `ST_T2`, `ST_T3`: the states of a cycle.

The transitions are:

- `ST_FREE` to `ST_T1`, `ST_GAP_A` or `ST_GAP_B` when a request is accepted, depending on how many idle states are owed.
- `ST_GAP_A` to `ST_GAP_B`.
- `ST_GAP_B` to `ST_T1`.
- `ST_T1` to `ST_T2`.
- `ST_T2` to `ST_T3` for a long access.
- From the last state, to a new cycle (directly or through an idle state) if a request is accepted, or back to `ST_FREE` if not.

Top module: `bus_idle_seq`

## Requirements
- R1: After reset all chip selects, `bus_rd_n` and `bus_wr_n` are high, `bus_dq_oe` is low, `req_ready` is high and `rd_valid` is low.
- R2: `req_ready` is low in every non-final cycle state and in idle states. It is high in the final state of a cycle and while the bus is free.
- R3: A cycle drives `bus_addr` with the request address. It asserts only the chip select whose index is `req_addr[15:13]`, in every state. A read holds `bus_rd_n` low in all its states. A write holds `bus_dq_oe` high with the write data in all its states, and drives `bus_wr_n` low in every state except T1. A cycle has 3 states when `req_long`=1 and 2 states otherwise.
- R4: For a read, the data on `bus_dq_i` in the final state is presented on `rd_data`, with `rd_valid` high, for the clock that follows.
- R5: A pulse on `cfg_we` loads `cfg_wdata` into the configuration register, which resets to 4'b1110. The bits are:
  - bit0: idle length (0 gives one state, 1 gives two states);
  - bit1: enable for a read to a different area after a read;
  - bit2: enable for a write after a read;
  - bit3: enable for a read after a write.
- R6: A read that follows a read to a different area is preceded by the idle length when bit1 is set, and by no idle state when bit1 is clear.
- R7: A write that follows a read is preceded by the idle length when bit2 is set, and by no idle state when bit2 is clear.
- R8: A read that follows a write is preceded by the idle length when bit3 is set, and by no idle state when bit3 is clear.
- R9: A read that follows a read to the same area, and a write that follows a write, get no idle state.
- R10: While no chip select is active, both strobes are high and `bus_dq_oe` is low.
- R11: Clocks spent with the bus free since the previous cycle count toward the idle length. The quiet time before a cycle that needs idling is the larger of the idle length and the free time.
- R12: With parameter `RAW_IDLE_EN`=0, a read that follows a write never gets an idle state, whatever bit3 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 4 | New configuration value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_long | input | 1 | Use the three-state cycle |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data available |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | AREAS | Per-area chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dq_o | output | DATA_W | Data driven onto the bus |
| bus_dq_oe | output | 1 | Data output enable; low means high impedance |
| bus_dq_i | input | DATA_W | Data read from the bus |

## Verification
The hardest case to reach is a partly elapsed free period. With a two-state idle length, the request arrives one clock after the previous cycle ends, so the sequencer must add exactly one `ST_GAP_B` state rather than two or none. The stimulus reaches it by dropping `req_valid`, waiting for the final state of the running cycle, and then holding off a chosen number of clocks before the next request. This way the free time before each checked cycle is known exactly. Back-to-back requests keep `req_valid` high across the final state so that each transition is exercised with zero free time. The idle count is then measured from the chip selects for every direction pair and enable setting.

// File: rtl/bis_pkg.sv
package bis_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_GAP_A,
        ST_GAP_B,
        ST_T1,
        ST_T2,
        ST_T3
    } bis_state_e;

    // Packed from MSB: field order gives cfg bit3..bit0.
    typedef struct packed {
        logic en_raw;      // bit3: read after write
        logic en_war;      // bit2: write after read
        logic en_diff_rd;  // bit1: read after read, other area
        logic idle_two;    // bit0: two idle states instead of one
    } bis_cfg_t;

    localparam logic [3:0] CFG_RESET = 4'b1110;

endpackage

// File: rtl/bis_gap_decide.sv
module bis_gap_decide
    import bis_pkg::*;
#(
    parameter int AREA_W      = 3,
    parameter bit RAW_IDLE_EN = 1'b1
) (
    input  logic              have_prev,
    input  logic              prev_write,
    input  logic [AREA_W-1:0] prev_area,
    input  logic              new_write,
    input  logic [AREA_W-1:0] new_area,
    input  bis_cfg_t          cfg,
    input  logic              from_free,
    input  logic [1:0]        free_cnt,
    output logic [1:0]        gaps
);
    logic       raw_en;
    logic       need;
    logic [1:0] len;
    logic [1:0] already;

    generate
        if (RAW_IDLE_EN) begin : g_raw
            assign raw_en = cfg.en_raw;
        end else begin : g_no_raw
            assign raw_en = 1'b0;
        end
    endgenerate

    always_comb begin
        need = 1'b0;
        if (have_prev) begin
            if (!prev_write && !new_write && (prev_area != new_area))
                need = cfg.en_diff_rd;
            else if (!prev_write && new_write)
                need = cfg.en_war;
            else if (prev_write && !new_write)
                need = raw_en;
        end
        len     = cfg.idle_two ? 2'd2 : 2'd1;
        already = !from_free ? 2'd0 : ((free_cnt != 2'd0) ? 2'd2 : 2'd1);
        gaps    = (need && (len > already)) ? (len - already) : 2'd0;
    end

endmodule

// File: rtl/bis_area_decode.sv
module bis_area_decode #(
    parameter int AREA_W = 3,
    localparam int AREAS = 1 << AREA_W
) (
    input  logic              en,
    input  logic [AREA_W-1:0] sel,
    output logic [AREAS-1:0]  cs_n
);
    generate
        for (genvar g = 0; g < AREAS; g++) begin : g_cs
            assign cs_n[g] = !(en && (sel == AREA_W'(g)));
        end
    endgenerate
endmodule

// File: rtl/bus_idle_seq.sv
module bus_idle_seq
    import bis_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int AREA_W      = 3,
    parameter bit RAW_IDLE_EN = 1'b1,
    localparam int AREAS      = 1 << AREA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_long,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AREAS-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dq_o,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_i
);
    bis_state_e        state, state_nx;
    bis_cfg_t          cfg;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_write, cur_long, have_prev;
    logic [1:0]        free_cnt, gaps;
    logic              accept, last, cs_en;
    logic [AREA_W-1:0] new_area, cur_area;

    assign new_area = req_addr[ADDR_W-1 -: AREA_W];
    assign cur_area = cur_addr[ADDR_W-1 -: AREA_W];
    assign last     = ((state == ST_T2) && !cur_long) || (state == ST_T3);
    assign req_ready = (state == ST_FREE) || last;
    assign accept   = req_valid && req_ready;

    bis_gap_decide #(.AREA_W(AREA_W), .RAW_IDLE_EN(RAW_IDLE_EN)) u_decide (
        .have_prev (have_prev),
        .prev_write(cur_write),
        .prev_area (cur_area),
        .new_write (req_write),
        .new_area  (new_area),
        .cfg       (cfg),
        .from_free (state == ST_FREE),
        .free_cnt  (free_cnt),
        .gaps      (gaps)
    );

    function automatic bis_state_e route(input logic [1:0] n);
        return (n == 2'd2) ? ST_GAP_A : ((n == 2'd1) ? ST_GAP_B : ST_T1);
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE:  state_nx = accept ? route(gaps) : ST_FREE;
            ST_GAP_A: state_nx = ST_GAP_B;
            ST_GAP_B: state_nx = ST_T1;
            ST_T1:    state_nx = ST_T2;
            ST_T2:    state_nx = cur_long ? ST_T3 : (accept ? route(gaps) : ST_FREE);
            ST_T3:    state_nx = accept ? route(gaps) : ST_FREE;
            default:  state_nx = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_FREE;
            cfg       <= bis_cfg_t'(CFG_RESET);
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_long  <= 1'b0;
            have_prev <= 1'b0;
            free_cnt  <= 2'd0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state <= state_nx;
            if (cfg_we)
                cfg <= bis_cfg_t'(cfg_wdata);
            if (accept) begin
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_write <= req_write;
                cur_long  <= req_long;
                have_prev <= 1'b1;
            end
            if (last)
                free_cnt <= 2'd0;
            else if ((state == ST_FREE) && (free_cnt != 2'd2))
                free_cnt <= free_cnt + 2'd1;
            rd_valid <= last && !cur_write;
            if (last && !cur_write)
                rd_data <= bus_dq_i;
        end
    end

    always_comb begin
        cs_en     = 1'b0;
        bus_rd_n  = 1'b1;
        bus_wr_n  = 1'b1;
        bus_dq_oe = 1'b0;
        unique case (state)
            ST_FREE, ST_GAP_A, ST_GAP_B: begin
                cs_en = 1'b0;
            end
            ST_T1: begin
                cs_en     = 1'b1;
                bus_rd_n  = cur_write;
                bus_dq_oe = cur_write;
            end
            ST_T2, ST_T3: begin
                cs_en     = 1'b1;
                bus_rd_n  = cur_write;
                bus_wr_n  = !cur_write;
                bus_dq_oe = cur_write;
            end
            default: cs_en = 1'b0;
        endcase
    end

    assign bus_addr = cur_addr;
    assign bus_dq_o = cur_wdata;

    bis_area_decode #(.AREA_W(AREA_W)) u_cs (
        .en  (cs_en),
        .sel (cur_area),
        .cs_n(bus_cs_n)
    );

endmodule

// File: rtl/bis_checker.sv
module bis_checker #(
    parameter int AREAS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AREAS-1:0] bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_wr_n,
    input logic             bus_dq_oe,
    input logic             rd_valid
);
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&bus_cs_n) |-> (bus_rd_n && bus_wr_n && !bus_dq_oe));

    a_r3_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n);

    a_r3_wr_after_t1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> !(&$past(bus_cs_n)));

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r4_rdv_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(bus_rd_n));
endmodule

bind bus_idle_seq bis_checker #(.AREAS(AREAS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_dq_oe(bus_dq_oe),
    .rd_valid (rd_valid)
);

// File: tb/tb_bus_idle_seq.sv
module tb_bus_idle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = 4'h0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data, bus_addr, bus_dq_o, bus_dq_i;
    logic [7:0]  bus_cs_n;
    logic        bus_rd_n, bus_wr_n, bus_dq_oe;

    logic        l_valid = 1'b0, l_write = 1'b0, l_ready, l_rdv;
    logic [15:0] l_addr = '0, l_rdd, l_baddr, l_dqo, l_dqi;
    logic [7:0]  l_cs_n;
    logic        l_rd_n, l_wr_n, l_oe;

    always #5 clk = ~clk;

    assign bus_dq_i = bus_addr ^ 16'h5A3C;
    assign l_dqi    = l_baddr ^ 16'h5A3C;

    bus_idle_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_long(req_long), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
    );

    bus_idle_seq #(.RAW_IDLE_EN(1'b0)) dut_lite (
        .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_wdata(4'h0),
        .req_valid(l_valid), .req_ready(l_ready), .req_addr(l_addr),
        .req_write(l_write), .req_long(1'b0), .req_wdata(16'h0),
        .rd_valid(l_rdv), .rd_data(l_rdd), .bus_addr(l_baddr),
        .bus_cs_n(l_cs_n), .bus_rd_n(l_rd_n), .bus_wr_n(l_wr_n),
        .bus_dq_o(l_dqo), .bus_dq_oe(l_oe), .bus_dq_i(l_dqi)
    );

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        bit          wr;
        bit          lng;
        int          gap;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0, n_bad = 0;

    // bench-side model state
    bit         m_prev_valid = 0, m_prev_wr = 0;
    int         m_prev_area = 0, next_nat = 0;
    logic [3:0] sh_cfg = 4'b1110;

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic issue(input logic [15:0] a, input bit wr, input bit lng,
                         input logic [15:0] d);
        item_t it;
        int    ar, len, g;
        bit    need;
        string tag;
        ar = int'(a[15:13]);
        need = 0;
        tag = "R9";
        if (!m_prev_wr && !wr && ar != m_prev_area) begin tag = "R6"; need = sh_cfg[1]; end
        else if (!m_prev_wr && wr) begin tag = "R7"; need = sh_cfg[2]; end
        else if (m_prev_wr && !wr) begin tag = "R8"; need = sh_cfg[3]; end
        len = sh_cfg[0] ? 2 : 1;
        g = need ? ((next_nat > len) ? next_nat : len) : next_nat;
        if (next_nat > 0) tag = {tag, "/R11"};
        if (!m_prev_valid) g = -1;
        it.addr = a; it.data = d; it.wr = wr; it.lng = lng; it.gap = g; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        cfg_we = 1'b0;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_long = lng; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        m_prev_valid = 1; m_prev_wr = wr; m_prev_area = ar; next_nat = 0;
    endtask

    task automatic pause(input int m, input bit docfg, input logic [3:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        if (docfg) begin cfg_we = 1'b1; cfg_wdata = v; sh_cfg = v; end
        repeat (m - 1) begin @(negedge clk); cfg_we = 1'b0; end
        next_nat = m;
    endtask

    // monitor
    int          gap_run = 0, st = 0, mlen = 0;
    bit          act = 0, pend = 0;
    item_t       cur;
    logic [15:0] exp_rd;
    logic [7:0]  exp_cs;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin gap_run = 0; act = 0; pend = 0; continue; end
            if (pend) begin
                chk(rd_valid == 1'b1, "R4", "rd_valid", rd_valid, 1);
                chk(rd_data == exp_rd, "R4", "rd_data", rd_data, exp_rd);
                pend = 0;
            end
            if (!act) begin
                if (&bus_cs_n) begin
                    gap_run++;
                    chk(bus_rd_n && bus_wr_n && !bus_dq_oe, "R10", "quiet strobes/oe",
                        {bus_rd_n, bus_wr_n, bus_dq_oe}, 3'b110);
                end else if (q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected cycle", bus_addr, 0);
                end else begin
                    cur = q.pop_front();
                    if (cur.gap >= 0)
                        chk(gap_run == cur.gap, cur.tag, "idle states", gap_run, cur.gap);
                    act = 1; st = 0;
                end
            end
            if (act) begin
                st++;
                mlen = cur.lng ? 3 : 2;
                exp_cs = 8'hFF;
                exp_cs[cur.addr[15:13]] = 1'b0;
                chk(bus_cs_n == exp_cs, "R3", "chip selects", bus_cs_n, exp_cs);
                chk(bus_addr == cur.addr, "R3", "address", bus_addr, cur.addr);
                if (cur.wr) begin
                    chk(bus_rd_n == 1'b1, "R3", "rd_n in write", bus_rd_n, 1);
                    chk(bus_wr_n == (st == 1), "R3", "wr_n in write", bus_wr_n, (st == 1));
                    chk(bus_dq_oe && bus_dq_o == cur.data, "R3", "write data",
                        bus_dq_o, cur.data);
                end else begin
                    chk(bus_rd_n == 1'b0 && bus_wr_n == 1'b1, "R3", "strobes in read",
                        {bus_rd_n, bus_wr_n}, 2'b01);
                    chk(bus_dq_oe == 1'b0, "R3", "oe in read", bus_dq_oe, 0);
                end
                chk(req_ready == (st == mlen), "R2", "ready in cycle state",
                    req_ready, (st == mlen));
                if (st == mlen) begin
                    act = 0; gap_run = 0;
                    if (!cur.wr) begin pend = 1; exp_rd = cur.addr ^ 16'h5A3C; end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        summary();
        $finish;
    end

    initial begin
        int idle_cnt;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(bus_cs_n == 8'hFF && bus_rd_n && bus_wr_n && !bus_dq_oe, "R1", "bus at reset",
            {bus_cs_n, bus_rd_n, bus_wr_n, bus_dq_oe}, 11'h7FE);
        chk(req_ready == 1'b1 && rd_valid == 1'b0, "R1", "ready/rd_valid at reset",
            {req_ready, rd_valid}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // default cfg 1110, length 1, back to back (R5 reset value)
        issue(16'h0010, 0, 0, 16'h0);
        issue(16'h0020, 0, 0, 16'h0);   // R9 same area read
        issue(16'h2000, 0, 0, 16'h0);   // R6
        issue(16'h2004, 1, 0, 16'hBEEF);// R7
        issue(16'h4000, 1, 0, 16'h1234);// R9 write-write
        issue(16'h4002, 0, 0, 16'h0);   // R8
        issue(16'h6000, 0, 1, 16'h0);   // R6, long
        issue(16'h6008, 1, 1, 16'hCAFE);// R7, long

        // R5 + R11: two-state length, partial free time
        pause(1, 1, 4'b1111);
        issue(16'h8000, 0, 0, 16'h0);   // R8 with 1 free clock -> 2
        issue(16'hA000, 0, 0, 16'h0);   // R6 -> 2
        issue(16'hA010, 1, 0, 16'h5555);// R7 -> 2
        issue(16'hA020, 0, 1, 16'h0);   // R8 -> 2
        pause(3, 0, 4'h0);
        issue(16'hC000, 0, 0, 16'h0);   // R6/R11 -> 3

        // all enables off, length two
        pause(1, 1, 4'b0001);
        issue(16'hE000, 0, 0, 16'h0);
        issue(16'hE002, 1, 0, 16'h0F0F);
        issue(16'hE004, 0, 0, 16'h0);
        issue(16'h0100, 0, 0, 16'h0);

        // only different-area reads, length one
        pause(1, 1, 4'b0010);
        issue(16'h0200, 0, 0, 16'h0);
        issue(16'h2200, 0, 0, 16'h0);
        issue(16'h2210, 1, 0, 16'hA5A5);
        issue(16'h2220, 0, 0, 16'h0);

        // only write-after-read
        pause(1, 1, 4'b0100);
        issue(16'h2230, 0, 0, 16'h0);
        issue(16'h2240, 1, 0, 16'h7777);
        issue(16'h2250, 0, 0, 16'h0);
        issue(16'h4250, 0, 0, 16'h0);

        // only read-after-write, then with length two
        pause(1, 1, 4'b1000);
        issue(16'h4260, 1, 0, 16'h1111);
        issue(16'h4270, 0, 0, 16'h0);
        issue(16'h4280, 0, 0, 16'h0);
        pause(1, 1, 4'b1001);
        issue(16'h4290, 1, 0, 16'h2222);
        issue(16'h42A0, 0, 0, 16'h0);

        pause(1, 0, 4'h0);
        repeat (8) @(negedge clk);
        chk(q.size() == 0, "R3", "cycles outstanding", q.size(), 0);

        // R12: variant without read-after-write idling (bit3 set at reset)
        @(negedge clk);
        l_valid = 1'b1; l_write = 1'b1; l_addr = 16'h0040;
        while (!l_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        l_write = 1'b0; l_addr = 16'h0044;
        idle_cnt = (&l_cs_n) ? 1 : 0;
        repeat (2) begin
            @(negedge clk);
            if (&l_cs_n) idle_cnt++;
        end
        l_valid = 1'b0;
        chk(idle_cnt == 0, "R12", "idle states read after write", idle_cnt, 0);
        chk(l_rd_n == 1'b0 && l_baddr == 16'h0044, "R12", "read started",
            {l_rd_n, l_baddr}, 17'h00044);
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule